// File: doc/BRIEF.md
# Compressed Line Sector Allocator

This block keeps the bookkeeping for a compressed main memory. Every logical line holds 1 KB of data before compression. Once compressed, it needs between zero and four 256-byte sectors. The block keeps one table entry for each line. An entry holds a valid flag, an in-entry flag, a sector count and four sector pointers, and it is protected by a parity bit. Free sectors sit on a singly linked stack. The link of each free sector is stored in an internal array next to its own parity bit.

A write request gives a line index and a compressed byte length. When the line is rewritten, the sectors it already holds go back to the stack one per cycle. The new number of sectors is then taken from the top of the stack one per cycle, and the entry is written. A line of 15 bytes or fewer (120 bits) is held inside its entry and uses no sectors. A read request returns the entry one cycle later. A configurable range of line indices is treated as uncompressed: those lines skip the table and are reported as directly addressed. Error and alarm outputs report parity faults, pointers beyond the configured sector limit, refused allocations and a used-sector count above a threshold.

Top module: `line_sector_mgr`

## Requirements
- R1: A write of length `len` asks for 0 sectors and sets the in-entry flag when `len` ≤ 15. Otherwise it asks for ceil(`len`/256) sectors, and a length above 1024 counts as 1024. A later read reports this count and the flag.
- R2: A write first pushes the line's current pointers onto the free stack in slot order 0,1,2,3. It then pops the sectors it needs from the top of the stack into slots 0 upward. Slots beyond the count read back as zero.
- R3: When free sectors plus the line's current sectors are fewer than the sectors needed, the write is refused. `done_ovf` pulses together with `done`, and the entry, the free stack and the used count stay unchanged.
- R4: An accepted write raises `done` for exactly one cycle. This happens 2 + old + new clock edges after the accepting edge, or 1 edge after it for a refused or bypassed write. `busy` is high from the accepting edge until `done` rises.
- R5: A read accepted while idle gives `rd_valid` for one cycle on the next edge, together with the entry's valid flag, in-entry flag, count and pointers.
- R6: A line with `cfg_raw_lo` ≤ index ≤ `cfg_raw_hi` is not changed by writes, which finish after 1 edge. A read of such a line reports `rd_direct`=1, count 0 and the other flags low.
- R7: `alarm` is high exactly while the number of sectors in use is above `cfg_thresh`.
- R8: `err_range` is set and held until reset when a sector pointer that is popped, pushed or read back is ≥ `cfg_sec_limit`.
- R9: Table entries and free-stack links each carry a parity bit that is checked on every use. `err_parity` is sticky and stays low while storage is intact.
- R10: After reset the block is busy for `cfg_sec_limit`+1 cycles while it builds the free stack. Pops then return sectors 0,1,2,… in order, every line reads back as not valid, and all error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sec_limit | input | CW | Number of usable sectors; pointers at or above it are out of range |
| cfg_thresh | input | CW | Used-sector alarm threshold |
| cfg_raw_lo | input | LW | First line of the uncompressed range |
| cfg_raw_hi | input | LW | Last line of the uncompressed range |
| wr_req | input | 1 | Write request, accepted while not busy |
| wr_line | input | LW | Line index to write |
| wr_len | input | 11 | Compressed length in bytes |
| rd_req | input | 1 | Read request, accepted while idle and no write is requested |
| rd_line | input | LW | Line index to read |
| busy | output | 1 | Initialisation or write in progress |
| done | output | 1 | One-cycle write completion pulse |
| done_ovf | output | 1 | Marks a completion that was refused for lack of sectors |
| rd_valid | output | 1 | Read result valid |
| rd_direct | output | 1 | Line is in the uncompressed range |
| rd_inline | output | 1 | Line is held inside its entry |
| rd_used | output | 1 | Entry has been written |
| rd_cnt | output | 3 | Number of sectors held |
| rd_ptrs | output | 4*SW | Sector pointers, slot 0 in the low bits |
| err_parity | output | 1 | Sticky parity error |
| err_range | output | 1 | Sticky out-of-range pointer error |
| alarm | output | 1 | Used sectors above threshold |

## Verification
Read data is due on the first edge after the request edge, so the bench samples it at the falling edge that follows. A write's `done` is due 2 + old + new edges after the accepting edge, or after one edge when the write is refused or bypassed. The bench counts rising edges from acceptance until it sees `done`, and checks the count against the value its own model gives. Flags and alarms are compared at that same falling edge. The initialisation length is also counted in edges after reset is released, and is checked against the configured sector limit plus one.

// File: rtl/line_sector_mgr.sv
module line_sector_mgr #(
  parameter int NUM_LINES   = 64,
  parameter int NUM_SECTORS = 64,
  localparam int LW = $clog2(NUM_LINES),
  localparam int SW = $clog2(NUM_SECTORS),
  localparam int CW = $clog2(NUM_SECTORS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cfg_sec_limit,
  input  logic [CW-1:0]   cfg_thresh,
  input  logic [LW-1:0]   cfg_raw_lo,
  input  logic [LW-1:0]   cfg_raw_hi,
  input  logic            wr_req,
  input  logic [LW-1:0]   wr_line,
  input  logic [10:0]     wr_len,
  input  logic            rd_req,
  input  logic [LW-1:0]   rd_line,
  output logic            busy,
  output logic            done,
  output logic            done_ovf,
  output logic            rd_valid,
  output logic            rd_direct,
  output logic            rd_inline,
  output logic            rd_used,
  output logic [2:0]      rd_cnt,
  output logic [4*SW-1:0] rd_ptrs,
  output logic            err_parity,
  output logic            err_range,
  output logic            alarm
);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_CHK, S_REL, S_ALLOC, S_COMMIT} st_t;

  typedef struct packed {
    logic                 par;
    logic                 vld;
    logic                 inl;
    logic [2:0]           cnt;
    logic [3:0][SW-1:0]   ptr;
  } ent_t;

  ent_t               tbl [NUM_LINES];
  logic [SW:0]        lnk [NUM_SECTORS];
  st_t                st;
  logic [SW-1:0]      head;
  logic [CW-1:0]      free_cnt, used_cnt, init_idx;
  logic [LW-1:0]      line_q;
  logic [2:0]         need_q, old_q;
  logic               inl_q;
  logic [1:0]         k;
  logic [3:0][SW-1:0] old_p, nptr;

  function automatic logic oor(input logic [SW-1:0] p, input logic [CW-1:0] l);
    return CW'(p) >= l;
  endfunction

  logic [10:0] len_c;
  logic        inl_c;
  logic [2:0]  need_c;
  assign len_c  = (wr_len > 11'd1024) ? 11'd1024 : wr_len;
  assign inl_c  = len_c <= 11'd15;
  assign need_c = inl_c ? 3'd0 : 3'((len_c + 11'd255) >> 8);

  logic [CW-1:0] lim;
  assign lim = (cfg_sec_limit > CW'(NUM_SECTORS)) ? CW'(NUM_SECTORS) : cfg_sec_limit;

  ent_t cur_ent, rd_ent;
  assign cur_ent = tbl[line_q];
  assign rd_ent  = tbl[rd_line];

  logic       byp_w, byp_r, ovf_c;
  logic [2:0] old_cnt_c;
  assign byp_w     = (line_q >= cfg_raw_lo) && (line_q <= cfg_raw_hi);
  assign byp_r     = (rd_line >= cfg_raw_lo) && (rd_line <= cfg_raw_hi);
  assign old_cnt_c = cur_ent.vld ? cur_ent.cnt : 3'd0;
  assign ovf_c     = ((CW+1)'(free_cnt) + (CW+1)'(old_cnt_c)) < (CW+1)'(need_q);

  logic [SW-1:0] rel_p;
  logic [SW:0]   top_lnk;
  assign rel_p   = old_p[k];
  assign top_lnk = lnk[head];

  logic          lk_we;
  logic [SW-1:0] lk_a, lk_nx;
  always_comb begin
    lk_we = 1'b0;
    lk_a  = '0;
    lk_nx = '0;
    if (st == S_INIT && init_idx < lim) begin
      lk_we = 1'b1;
      lk_a  = SW'(init_idx);
      lk_nx = (init_idx == lim - CW'(1)) ? '0 : SW'(init_idx + CW'(1));
    end else if (st == S_REL) begin
      lk_we = 1'b1;
      lk_a  = rel_p;
      lk_nx = head;
    end
  end

  always_ff @(posedge clk)
    if (lk_we) lnk[lk_a] <= {^lk_nx, lk_nx};

  assign busy  = st != S_IDLE;
  assign alarm = used_cnt > cfg_thresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_INIT;
      head       <= '0;
      free_cnt   <= '0;
      used_cnt   <= '0;
      init_idx   <= '0;
      line_q     <= '0;
      need_q     <= '0;
      old_q      <= '0;
      inl_q      <= 1'b0;
      k          <= '0;
      old_p      <= '0;
      nptr       <= '0;
      done       <= 1'b0;
      done_ovf   <= 1'b0;
      rd_valid   <= 1'b0;
      rd_direct  <= 1'b0;
      rd_inline  <= 1'b0;
      rd_used    <= 1'b0;
      rd_cnt     <= '0;
      rd_ptrs    <= '0;
      err_parity <= 1'b0;
      err_range  <= 1'b0;
      for (int i = 0; i < NUM_LINES; i++) tbl[i] <= '0;
    end else begin
      done     <= 1'b0;
      done_ovf <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_INIT: begin
          if (init_idx >= lim) begin
            st       <= S_IDLE;
            free_cnt <= lim;
            head     <= '0;
          end else begin
            init_idx <= init_idx + CW'(1);
          end
        end
        S_IDLE: begin
          if (wr_req) begin
            line_q <= wr_line;
            need_q <= need_c;
            inl_q  <= inl_c;
            st     <= S_CHK;
          end else if (rd_req) begin
            rd_valid <= 1'b1;
            if (byp_r) begin
              rd_direct <= 1'b1;
              rd_inline <= 1'b0;
              rd_used   <= 1'b0;
              rd_cnt    <= '0;
              rd_ptrs   <= '0;
            end else begin
              rd_direct <= 1'b0;
              rd_used   <= rd_ent.vld;
              rd_inline <= rd_ent.vld & rd_ent.inl;
              rd_cnt    <= rd_ent.vld ? rd_ent.cnt : 3'd0;
              rd_ptrs   <= rd_ent.vld ? rd_ent.ptr : '0;
              if (^rd_ent) err_parity <= 1'b1;
              for (int i = 0; i < 4; i++)
                if (rd_ent.vld && i < int'(rd_ent.cnt) && oor(rd_ent.ptr[i], cfg_sec_limit))
                  err_range <= 1'b1;
            end
          end
        end
        S_CHK: begin
          if (^cur_ent) err_parity <= 1'b1;
          if (byp_w) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (ovf_c) begin
            done     <= 1'b1;
            done_ovf <= 1'b1;
            st       <= S_IDLE;
          end else begin
            old_p <= cur_ent.ptr;
            old_q <= old_cnt_c;
            nptr  <= '0;
            k     <= '0;
            if (old_cnt_c != 3'd0)    st <= S_REL;
            else if (need_q != 3'd0)  st <= S_ALLOC;
            else                      st <= S_COMMIT;
          end
        end
        S_REL: begin
          head     <= rel_p;
          free_cnt <= free_cnt + CW'(1);
          used_cnt <= used_cnt - CW'(1);
          if (oor(rel_p, cfg_sec_limit)) err_range <= 1'b1;
          if ({1'b0, k} == old_q - 3'd1) begin
            k  <= '0;
            st <= (need_q != 3'd0) ? S_ALLOC : S_COMMIT;
          end else begin
            k <= k + 2'd1;
          end
        end
        S_ALLOC: begin
          nptr[k]  <= head;
          head     <= top_lnk[SW-1:0];
          free_cnt <= free_cnt - CW'(1);
          used_cnt <= used_cnt + CW'(1);
          if (^top_lnk) err_parity <= 1'b1;
          if (oor(head, cfg_sec_limit)) err_range <= 1'b1;
          if ({1'b0, k} == need_q - 3'd1) begin
            k  <= '0;
            st <= S_COMMIT;
          end else begin
            k <= k + 2'd1;
          end
        end
        S_COMMIT: begin
          tbl[line_q] <= '{par: ^{1'b1, inl_q, need_q, nptr}, vld: 1'b1,
                           inl: inl_q, cnt: need_q, ptr: nptr};
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module line_sector_mgr_chk #(
  parameter int CW = 7,
  parameter int NS = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          done_ovf,
  input logic          wr_req,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          rd_direct,
  input logic          rd_inline,
  input logic [2:0]    rd_cnt,
  input logic          err_range,
  input logic          err_parity,
  input logic [CW-1:0] used_cnt
);

  p_cnt_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_cnt <= 3'd4);

  p_inline_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_inline |-> rd_cnt == 3'd0);

  p_ovf_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_ovf |-> done);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_rd_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req) && !$past(wr_req));

  p_direct_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_direct |-> rd_cnt == 3'd0 && !rd_inline);

  p_used_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= CW'(NS));

  p_used_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt == $past(used_cnt) || used_cnt == $past(used_cnt) + CW'(1) ||
    used_cnt == $past(used_cnt) - CW'(1));

  p_range_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |=> err_range);

  p_parity_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> err_parity);

endmodule

bind line_sector_mgr line_sector_mgr_chk #(.CW(CW), .NS(NUM_SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .done_ovf(done_ovf),
  .wr_req(wr_req), .rd_req(rd_req), .rd_valid(rd_valid), .rd_direct(rd_direct),
  .rd_inline(rd_inline), .rd_cnt(rd_cnt), .err_range(err_range),
  .err_parity(err_parity), .used_cnt(used_cnt)
);

// File: tb/sim_line_sector_mgr.sv
module sim_line_sector_mgr;
  localparam int NL = 64;
  localparam int NS = 64;
  localparam int LW = 6;
  localparam int SW = 6;
  localparam int CW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [CW-1:0] cfg_sec_limit, cfg_thresh;
  logic [LW-1:0] cfg_raw_lo, cfg_raw_hi;
  logic wr_req, rd_req;
  logic [LW-1:0] wr_line, rd_line;
  logic [10:0] wr_len;
  logic busy, done, done_ovf, rd_valid, rd_direct, rd_inline, rd_used;
  logic [2:0] rd_cnt;
  logic [4*SW-1:0] rd_ptrs;
  logic err_parity, err_range, alarm;

  line_sector_mgr #(.NUM_LINES(NL), .NUM_SECTORS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sec_limit(cfg_sec_limit), .cfg_thresh(cfg_thresh),
    .cfg_raw_lo(cfg_raw_lo), .cfg_raw_hi(cfg_raw_hi), .wr_req(wr_req), .wr_line(wr_line),
    .wr_len(wr_len), .rd_req(rd_req), .rd_line(rd_line), .busy(busy), .done(done),
    .done_ovf(done_ovf), .rd_valid(rd_valid), .rd_direct(rd_direct), .rd_inline(rd_inline),
    .rd_used(rd_used), .rd_cnt(rd_cnt), .rd_ptrs(rd_ptrs), .err_parity(err_parity),
    .err_range(err_range), .alarm(alarm));

  int checks = 0, errors = 0;
  int m_vld[NL], m_inl[NL], m_cnt[NL];
  int m_ptr[NL][4];
  int stk[NS];
  int sp, used, cur_lim, thr, raw_lo, raw_hi;
  bit ex_rng;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int need_of(int len);
    int l = (len > 1024) ? 1024 : len;
    if (l <= 15) return 0;
    return (l + 255) / 256;
  endfunction

  function automatic bit is_raw(int ln);
    return ln >= raw_lo && ln <= raw_hi;
  endfunction

  task automatic common_flags();
    chk("R7", "alarm", int'(alarm), int'(used > thr));
    chk("R8", "err_range", int'(err_range), int'(ex_rng));
    chk("R9", "err_parity", int'(err_parity), 0);
  endtask

  task automatic wr(int ln, int len);
    int old, need, lat, exp_lat, exp_ovf, p;
    need = need_of(len);
    exp_ovf = 0;
    if (is_raw(ln)) exp_lat = 1;
    else begin
      old = m_vld[ln] ? m_cnt[ln] : 0;
      if (sp + old < need) begin exp_lat = 1; exp_ovf = 1; end
      else begin
        exp_lat = 2 + old + need;
        for (int i = 0; i < old; i++) begin
          if (m_ptr[ln][i] >= cur_lim) ex_rng = 1;
          stk[sp] = m_ptr[ln][i]; sp++; used--;
        end
        for (int i = 0; i < 4; i++) begin
          if (i < need) begin
            sp--; p = stk[sp]; used++;
            if (p >= cur_lim) ex_rng = 1;
            m_ptr[ln][i] = p;
          end else m_ptr[ln][i] = 0;
        end
        m_vld[ln] = 1; m_cnt[ln] = need; m_inl[ln] = int'(need_of(len) == 0);
      end
    end
    @(negedge clk);
    wr_req = 1'b1; wr_line = LW'(ln); wr_len = 11'(len);
    @(posedge clk);
    @(negedge clk);
    wr_req = 1'b0;
    chk("R4", "busy after accept", int'(busy), 1);
    lat = 0;
    do begin
      @(posedge clk); lat++; @(negedge clk);
    end while (!done && lat < 40);
    chk("R4", "write latency", lat, exp_lat);
    chk("R4", "busy at done", int'(busy), 0);
    chk("R3", "done_ovf", int'(done_ovf), exp_ovf);
    common_flags();
  endtask

  task automatic rd(int ln);
    @(negedge clk);
    rd_req = 1'b1; rd_line = LW'(ln);
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    chk("R5", "rd_valid", int'(rd_valid), 1);
    if (is_raw(ln)) begin
      chk("R6", "rd_direct", int'(rd_direct), 1);
      chk("R6", "rd_cnt raw", int'(rd_cnt), 0);
      chk("R6", "rd_used raw", int'(rd_used), 0);
    end else begin
      chk("R6", "rd_direct", int'(rd_direct), 0);
      chk("R5", "rd_used", int'(rd_used), m_vld[ln]);
      chk("R1", "rd_inline", int'(rd_inline), m_vld[ln] ? m_inl[ln] : 0);
      chk("R1", "rd_cnt", int'(rd_cnt), m_vld[ln] ? m_cnt[ln] : 0);
      for (int i = 0; i < 4; i++) begin
        chk("R2", "rd_ptr slot", int'(rd_ptrs[i*SW +: SW]), m_vld[ln] ? m_ptr[ln][i] : 0);
        if (m_vld[ln] && i < m_cnt[ln] && m_ptr[ln][i] >= cur_lim) ex_rng = 1;
      end
    end
    common_flags();
    @(negedge clk);
    chk("R5", "rd_valid one cycle", int'(rd_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; wr_line = '0; rd_line = '0; wr_len = '0;
    cur_lim = 16; thr = 10; raw_lo = 48; raw_hi = 55;
    cfg_sec_limit = CW'(cur_lim); cfg_thresh = CW'(thr);
    cfg_raw_lo = LW'(raw_lo); cfg_raw_hi = LW'(raw_hi);
    for (int i = 0; i < NL; i++) begin
      m_vld[i] = 0; m_inl[i] = 0; m_cnt[i] = 0;
      for (int j = 0; j < 4; j++) m_ptr[i][j] = 0;
    end
    for (int i = 0; i < cur_lim; i++) stk[i] = cur_lim - 1 - i;
    sp = cur_lim; used = 0; ex_rng = 0;

    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", int'(busy), 1);
    chk("R10", "done in reset", int'(done), 0);
    chk("R10", "err_range in reset", int'(err_range), 0);
    chk("R10", "err_parity in reset", int'(err_parity), 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (busy && n < 1000);
    chk("R10", "init cycles", n, cur_lim + 1);
    rd(3);

    wr(0, 15);   rd(0);
    wr(1, 16);   rd(1);
    wr(2, 256);  rd(2);
    wr(3, 257);  rd(3);
    wr(4, 1024); rd(4);
    wr(5, 2000); rd(5);
    wr(4, 300);  rd(4);
    wr(6, 1024); rd(6);
    wr(7, 1024); rd(7);
    wr(6, 1024); rd(6);
    wr(0, 0);    rd(0);
    wr(50, 500); rd(50);

    for (int it = 0; it < 300; it++) begin
      int ln, len;
      ln  = ($urandom_range(0, 9) == 0) ? 50 : int'($urandom_range(0, 11));
      len = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 20)) : int'($urandom_range(0, 1100));
      if ($urandom_range(0, 2) == 0) rd(ln);
      else wr(ln, len);
    end

    for (int i = 0; i < 12; i++) wr(i, 0);
    thr = 0; cfg_thresh = '0;
    @(negedge clk);
    chk("R7", "alarm with nothing used", int'(alarm), 0);
    wr(0, 1024);
    chk("R8", "range clear before limit drop", int'(err_range), 0);
    cur_lim = 1; cfg_sec_limit = CW'(1);
    rd(0);
    chk("R8", "range set after limit drop", int'(err_range), 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule